// File: doc/BRIEF.md
# I/O Cell Capture and Drive Registers

This block holds the storage elements of one programmable I/O cell, split into an inbound path and an outbound path. On the inbound side, a pad sample is first held by a fast-capture latch. That latch is timed by the output-side clock. The held value is then handed to a second storage stage on the input clock, so the two inbound elements can run from unrelated clocks. By parameter, the second stage is either an edge-triggered flop or a level-sensitive latch.

On the outbound side, core data can be inverted. It then either goes straight to the pad or passes through a flop that has a clock enable and a configurable set/reset value. A global set/reset forces that flop at once. The flop is released only in step with the output clock. A 3-state control turns the pad driver off whatever the data. Each of the two clocks has its own polarity option, and all mode choices are elaboration-time parameters.

Top module: `iocell_regpath`

## Requirements
- R1: With default clock polarity, the capture latch is transparent while `oclk_i` is low and holds while it is high. A pad change made while `oclk_i` is high does not reach `din_o` through the following rising edge of `iclk_i`.
- R2: With `STAGE2 = STG2_FLOP` (default), `din_o` updates only on the rising edge of the effective input clock. With `STAGE2 = STG2_LATCH`, `din_o` follows the capture latch while the effective input clock is high and holds while it is low.
- R3: Setting `OCLK_INV` or `ICLK_INV` to 1 inverts that clock before it reaches its storage elements. With both set, the capture latch is open while `oclk_i` is high, and the latch second stage is open while `iclk_i` is low.
- R4: When `OUT_INV = 1`, the value driven on `pad_o` is the complement of `dout_i`. With `OUT_INV = 0` it is true polarity.
- R5: When `OUT_REG = 1` (default), `pad_o` changes only on a rising effective output clock edge where `ce_i` is high. When `OUT_REG = 0`, `pad_o` follows `dout_i` combinationally.
- R6: While `ce_i` is low, the output flop keeps its value across output clock edges.
- R7: While `gsr_ni` is low, the output flop holds `SR_VAL` (default 0). This takes effect at once, without a clock edge, and overrides `ce_i` and data.
- R8: After `gsr_ni` rises, the output flop stays at `SR_VAL` through the first two rising output clock edges. It loads data from the third edge on.
- R9: `pad_oe_o` is 0 (pad in high impedance) whenever `t_i` is 1, whatever the data. It is 1 whenever `t_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oclk_i | input | 1 | Output-side clock; also times the capture latch |
| iclk_i | input | 1 | Input clock for the second inbound stage |
| gsr_ni | input | 1 | Global set/reset, active low, asynchronous assert |
| ce_i | input | 1 | Clock enable of the output flop |
| t_i | input | 1 | 3-state control, 1 turns the driver off |
| dout_i | input | 1 | Core data toward the pad |
| pad_i | input | 1 | Data arriving from the pad |
| pad_o | output | 1 | Data driven onto the pad |
| pad_oe_o | output | 1 | Pad driver enable, 1 drives |
| din_o | output | 1 | Captured pad data toward the core |

## Verification
A capture latch that stays open during the high phase of the output clock lets a late pad change through. That shows up on `din_o` at the very next input clock edge, two time units after the output clock rises. A wrong hold or enable decision in the output flop shows on `pad_o` one output clock edge after the stimulus. A faulty reset synchronizer shows as data appearing one or two edges early after release. A wrong 3-state decode is visible on `pad_oe_o` in the same cycle.

// File: rtl/iocell_pkg.sv
package iocell_pkg;

  typedef enum logic {
    STG2_FLOP  = 1'b0,
    STG2_LATCH = 1'b1
  } stage2_e;

endpackage

// File: rtl/iocell_clk_pol.sv
module iocell_clk_pol #(
  parameter bit INVERT = 1'b0
) (
  input  logic clk_i,
  output logic clk_o
);

  generate
    if (INVERT) begin : g_inv
      assign clk_o = ~clk_i;
    end else begin : g_pass
      assign clk_o = clk_i;
    end
  endgenerate

endmodule

// File: rtl/iocell_rst_sync.sv
module iocell_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);

  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d[0] = 1'b1;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[LAST];

endmodule

// File: rtl/iocell_in_path.sv
module iocell_in_path #(
  parameter iocell_pkg::stage2_e STAGE2 = iocell_pkg::STG2_FLOP
) (
  input  logic cap_clk_i,
  input  logic stg_clk_i,
  input  logic rst_ni,
  input  logic pad_i,
  output logic din_o
);

  logic cap_q;

  // Fast-capture latch: open while its clock is low.
  always_latch begin
    if (!cap_clk_i) cap_q <= pad_i;
  end

  generate
    if (STAGE2 == iocell_pkg::STG2_FLOP) begin : g_flop
      logic s2_q;
      always_ff @(posedge stg_clk_i) begin
        s2_q <= cap_q;
      end
      assign din_o = s2_q;

      // R2: second stage presents what the latch held at the prior edge
      p_stage2_flop_r2: assert property (@(posedge stg_clk_i) disable iff (!rst_ni)
        1'b1 |=> (s2_q == $past(cap_q)));
    end else begin : g_latch
      logic s2_q;
      always_latch begin
        if (stg_clk_i) s2_q <= cap_q;
      end
      assign din_o = s2_q;
    end
  endgenerate

  // Assertion helper: pad value at the moment the capture latch closes.
  logic close_smp_q;
  always_ff @(posedge cap_clk_i) begin
    close_smp_q <= pad_i;
  end

  // R1: while closed, the latch keeps the value present at closing
  p_cap_closed_r1: assert property (@(negedge cap_clk_i) disable iff (!rst_ni)
    cap_q == close_smp_q);

endmodule

// File: rtl/iocell_out_path.sv
module iocell_out_path #(
  parameter bit OUT_INV    = 1'b0,
  parameter bit OUT_REG    = 1'b1,
  parameter bit SR_VAL     = 1'b0,
  parameter int RST_STAGES = 2
) (
  input  logic clk_i,
  input  logic gsr_ni,
  input  logic ce_i,
  input  logic t_i,
  input  logic dout_i,
  output logic pad_o,
  output logic pad_oe_o
);

  logic d_pol;

  generate
    if (OUT_INV) begin : g_dinv
      assign d_pol = ~dout_i;
    end else begin : g_dtrue
      assign d_pol = dout_i;
    end
  endgenerate

  generate
    if (OUT_REG) begin : g_reg
      logic rst_n;
      logic oreg_d;
      logic oreg_q;

      iocell_rst_sync #(.STAGES(RST_STAGES)) u_rst_sync (
        .clk_i   (clk_i),
        .arst_ni (gsr_ni),
        .rst_no  (rst_n)
      );

      always_comb begin
        oreg_d = oreg_q;
        if (ce_i) oreg_d = d_pol;
      end

      always_ff @(posedge clk_i or negedge rst_n) begin
        if (!rst_n) oreg_q <= SR_VAL;
        else        oreg_q <= oreg_d;
      end

      assign pad_o = oreg_q;

      // R5: an enabled edge loads the (possibly inverted) data
      p_load_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
        (rst_n && ce_i) |=> (oreg_q == $past(d_pol)));
      // R6: a disabled edge leaves the flop unchanged
      p_ce_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n)
        (rst_n && !ce_i) |=> $stable(oreg_q));
      // R7: global set/reset overrides everything
      p_gsr_force_r7: assert property (@(posedge clk_i) disable iff (gsr_ni)
        oreg_q == SR_VAL);
      // R8: first enabled edge after release still sees the reset value
      p_release_r8: assert property (@(posedge clk_i) disable iff (!gsr_ni)
        $rose(rst_n) |-> (oreg_q == SR_VAL));
    end else begin : g_bypass
      assign pad_o = d_pol;
    end
  endgenerate

  assign pad_oe_o = ~t_i;

endmodule

// File: rtl/iocell_regpath.sv
module iocell_regpath #(
  parameter iocell_pkg::stage2_e STAGE2     = iocell_pkg::STG2_FLOP,
  parameter bit                  OCLK_INV   = 1'b0,
  parameter bit                  ICLK_INV   = 1'b0,
  parameter bit                  OUT_INV    = 1'b0,
  parameter bit                  OUT_REG    = 1'b1,
  parameter bit                  SR_VAL     = 1'b0,
  parameter int                  RST_STAGES = 2
) (
  input  logic oclk_i,
  input  logic iclk_i,
  input  logic gsr_ni,
  input  logic ce_i,
  input  logic t_i,
  input  logic dout_i,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe_o,
  output logic din_o
);

  logic ock;
  logic ick;

  iocell_clk_pol #(.INVERT(OCLK_INV)) u_opol (.clk_i(oclk_i), .clk_o(ock));
  iocell_clk_pol #(.INVERT(ICLK_INV)) u_ipol (.clk_i(iclk_i), .clk_o(ick));

  iocell_in_path #(.STAGE2(STAGE2)) u_in (
    .cap_clk_i (ock),
    .stg_clk_i (ick),
    .rst_ni    (gsr_ni),
    .pad_i     (pad_i),
    .din_o     (din_o)
  );

  iocell_out_path #(
    .OUT_INV    (OUT_INV),
    .OUT_REG    (OUT_REG),
    .SR_VAL     (SR_VAL),
    .RST_STAGES (RST_STAGES)
  ) u_out (
    .clk_i    (ock),
    .gsr_ni   (gsr_ni),
    .ce_i     (ce_i),
    .t_i      (t_i),
    .dout_i   (dout_i),
    .pad_o    (pad_o),
    .pad_oe_o (pad_oe_o)
  );

  // R9: driver off whenever 3-state control is high, on otherwise
  p_hiz_r9: assert property (@(posedge oclk_i) disable iff (!gsr_ni)
    t_i |-> !pad_oe_o);
  p_drive_r9: assert property (@(posedge oclk_i) disable iff (!gsr_ni)
    !t_i |-> pad_oe_o);

endmodule

// File: tb/iocell_regpath_tb_top.sv
`timescale 1ns/1ps
module iocell_regpath_tb_top;

  logic oclk, iclk, gsr_n, ce, t, dout, pad_i;
  logic pad_o, pad_oe, din;
  logic alt_pad_o, alt_pad_oe, alt_din;

  typedef struct {
    string req;
    int    sig;
    logic  exp;
  } exp_item_t;

  exp_item_t exp_q[$];
  event      sample_ev;
  int        checks   = 0;
  int        failures = 0;
  bit        done     = 0;

  initial oclk = 1'b0;
  always #5 oclk = ~oclk;
  initial begin
    iclk = 1'b0;
    #7 iclk = 1'b1;
    forever #5 iclk = ~iclk;
  end

  iocell_regpath dut_i (
    .oclk_i(oclk), .iclk_i(iclk), .gsr_ni(gsr_n), .ce_i(ce), .t_i(t),
    .dout_i(dout), .pad_i(pad_i), .pad_o(pad_o), .pad_oe_o(pad_oe), .din_o(din)
  );

  iocell_regpath #(
    .STAGE2(iocell_pkg::STG2_LATCH), .OCLK_INV(1'b1), .ICLK_INV(1'b1),
    .OUT_INV(1'b1), .OUT_REG(1'b0), .SR_VAL(1'b1)
  ) dut_alt_i (
    .oclk_i(oclk), .iclk_i(iclk), .gsr_ni(gsr_n), .ce_i(ce), .t_i(t),
    .dout_i(dout), .pad_i(pad_i), .pad_o(alt_pad_o), .pad_oe_o(alt_pad_oe),
    .din_o(alt_din)
  );

  function automatic logic pick(int sig);
    case (sig)
      0:       return pad_o;
      1:       return pad_oe;
      2:       return din;
      3:       return alt_pad_o;
      default: return alt_din;
    endcase
  endfunction

  // Driver side: queue an expectation and wake the monitor.
  task automatic expect_sig(string req, int sig, logic val);
    exp_q.push_back('{req: req, sig: sig, exp: val});
    -> sample_ev;
    #0;
  endtask

  // Monitor: pop and compare against the live outputs.
  initial begin
    forever begin
      @(sample_ev);
      while (exp_q.size() > 0) begin
        exp_item_t it;
        logic act;
        it  = exp_q.pop_front();
        act = pick(it.sig);
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s sig=%0d actual=%b expected=%b at %0t",
                   it.req, it.sig, act, it.exp, $time);
        end
      end
    end
  end

  task automatic cap_main(logic a, logic b);
    @(negedge oclk);
    #2 pad_i = a;
    @(posedge oclk);
    #1 pad_i = b;
    #2 expect_sig("R1", 2, a);
    #5 expect_sig("R2", 2, a);
    #5 expect_sig("R2", 2, b);
  endtask

  task automatic cap_alt(logic a, logic b);
    @(posedge oclk);
    #1 pad_i = a;
    #5 pad_i = b;
    #2 expect_sig("R3", 4, a);
    #3 expect_sig("R2", 4, b);
    #2 pad_i = ~b;
    #1 expect_sig("R2", 4, b);
  endtask

  initial begin
    gsr_n = 1'b0; ce = 1'b1; t = 1'b0; dout = 1'b1; pad_i = 1'b0;
    #3;
    expect_sig("R7", 0, 1'b0);
    expect_sig("R9", 1, 1'b1);
    expect_sig("R4", 3, 1'b0);
    dout = 1'b0;
    #1 expect_sig("R5", 3, 1'b1);
    dout = 1'b1;
    @(posedge oclk); @(posedge oclk);
    #1 expect_sig("R7", 0, 1'b0);
    #2 gsr_n = 1'b1;
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b0);
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b0);
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b1);
    #2 ce = 1'b0; dout = 1'b0;
    @(posedge oclk); #1 expect_sig("R6", 0, 1'b1);
    @(posedge oclk); #1 expect_sig("R6", 0, 1'b1);
    #2 ce = 1'b1;
    #2 expect_sig("R5", 0, 1'b1);
    @(posedge oclk); #1 expect_sig("R5", 0, 1'b0);
    #1 t = 1'b1;
    #1 expect_sig("R9", 1, 1'b0);
    dout = 1'b1;
    @(posedge oclk); #1 expect_sig("R9", 1, 1'b0);
    expect_sig("R5", 0, 1'b1);
    t = 1'b0;
    #1 expect_sig("R9", 1, 1'b1);
    #1 gsr_n = 1'b0;
    #1 expect_sig("R7", 0, 1'b0);
    @(posedge oclk); #1 expect_sig("R7", 0, 1'b0);
    #2 gsr_n = 1'b1;
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b0);
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b0);
    @(posedge oclk); #1 expect_sig("R8", 0, 1'b1);
    cap_main(1'b1, 1'b0);
    cap_main(1'b0, 1'b1);
    cap_main(1'b1, 1'b1);
    cap_main(1'b0, 1'b0);
    cap_alt(1'b1, 1'b0);
    cap_alt(1'b0, 1'b1);
    cap_alt(1'b1, 1'b1);
    #5;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule